// File: doc/BRIEF.md
# Endian-Aware Local Window Decoder

This block sits between a host-side access port and four plug-in module slots. A host access names one of four windows, an address, a size (one byte or two) and, for writes, the data. The decoder splits the address into a slot number, an address-space code and an offset; each window does this in its own way. It drives a one-hot select for the slot that was hit. All decode results are registered, so they appear one clock after the access is presented. Read data coming back from the slot is corrected and returned on the same cycle.

Three of the windows can each be switched to big-endian byte order. A byte access in such a window has address bit 0 inverted before decoding. A halfword access has its two data bytes exchanged, for write data and for read data alike. The three mode bits sit in bit 0 of three bytes of a byte-wide configuration space. The other bytes of that space return a computed constant.

The decoder flags accesses of an illegal size as errors and selects no slot for them. An access to an empty slot selects nothing, raises no error and reads back as zero.

Top module: `lwin_decoder`

## Requirements
- R1: While reset is low and after its release, `dec_valid`, `dec_err`, `dec_ctl`, `dec_sel` and `host_rdata` are 0. All three big-endian bits are 0 after reset.
- R2: Window code 1 (register window) decodes the effective address as follows. The slot is ea[9:8] and the space field is ea[7:6]. Field 2 gives space code 1 (identification) with offset ea[5:0]. Field 3 gives space code 2 (interrupt) with offset ea[5:0]. Fields 0 and 1 give space code 0 (I/O) with offset ea[6:0].
- R3: Window code 2 (halfword memory) gives slot ea[24:23], space code 3 and offset ea[22:0].
- R4: Window code 3 (byte memory) gives slot ea[23:22], space code 3 and offset ea[21:0]. No byte-order correction is ever applied in this window.
- R5: In windows 0 to 2, when the window's big-endian bit is set, a byte access (`acc_size`=0) decodes with address bit 0 inverted. Otherwise the effective address equals `acc_addr`.
- R6: In windows 0 to 2, when the window's big-endian bit is set, a halfword access (`acc_size`=1) swaps the two bytes of `dec_wdata` relative to `acc_wdata`, and the two bytes of `host_rdata` relative to `mod_rdata`.
- R7: A configuration write to byte 0x2B, 0x2F or 0x33 stores `cfg_wdata[0]` as the big-endian bit of window 0, 1 or 2 respectively. Writes to any other byte have no effect.
- R8: A configuration read of byte a < 88 returns ((a*29 mod 256) XOR 0xA6) with bit 0 cleared. At bytes 0x2B, 0x2F and 0x33, that value is ORed with the stored bit. A read at a >= 88 returns 0.
- R9: Window 0 (control) accepts only halfword accesses and window 3 only byte accesses. An illegal size sets `dec_err`, and `dec_sel` stays 0.
- R10: A legal access in windows 1 to 3 to a slot whose `slot_present` bit is 0 asserts no select and no error. A read of that slot returns 0 on `host_rdata`.
- R11: Results appear one cycle after `acc_valid`, for exactly one cycle. A legal window 1 to 3 access to a present slot s gives `dec_sel` = 1<<s. A legal window 0 access sets `dec_ctl`, selects no slot, and returns read data from `mod_rdata`. `dec_wdata` is 0 for reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| acc_valid | input | 1 | Host access present this cycle |
| acc_win | input | 2 | Window: 0 control, 1 register, 2 halfword memory, 3 byte memory |
| acc_addr | input | 25 | Byte address within the window |
| acc_size | input | 1 | 0 = one byte, 1 = two bytes |
| acc_wr | input | 1 | 1 = write |
| acc_wdata | input | 16 | Host write data |
| slot_present | input | 4 | Per-slot installed flag |
| mod_rdata | input | 16 | Raw read data from the slot or control bank |
| cfg_en | input | 1 | Configuration write enable qualifier |
| cfg_wr | input | 1 | Configuration write |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data (combinational) |
| dec_valid | output | 1 | Decoded access valid |
| dec_wr | output | 1 | Decoded access is a write |
| dec_ctl | output | 1 | Legal access to the control window |
| dec_err | output | 1 | Illegal access size |
| dec_slot | output | 2 | Decoded slot number |
| dec_space | output | 2 | Space code: 0 I/O, 1 ID, 2 interrupt, 3 memory |
| dec_offset | output | 23 | Offset within the space |
| dec_wdata | output | 16 | Lane-corrected write data |
| dec_sel | output | 4 | One-hot slot select |
| host_rdata | output | 16 | Lane-corrected read data, zero for absent slots |

## Verification
On every cycle the assertions check four things. Select is one-hot or zero. An error never coexists with a select. A decode follows each access by exactly one cycle. Reads of an unselected slot return zero. They also check that the byte-memory window passes write data untouched, that an illegal control-window size is flagged, and that a mode write lands in its bit. The bench sweeps every combination of the three mode bits against all windows, both sizes, reads and writes, empty slots and spread addresses. Only that sweep shows the per-window address carving, the bit-0 inversion and the lane swap of both data paths. The bench also reads the whole configuration space, covering the computed constants and the three writable bits.

// File: rtl/lwd_pkg.sv
package lwd_pkg;
   typedef enum logic [1:0] {
      WIN_CTL   = 2'd0,
      WIN_REGIO = 2'd1,
      WIN_MEM16 = 2'd2,
      WIN_MEM8  = 2'd3
   } win_e;

   typedef enum logic [1:0] {
      SP_IO  = 2'd0,
      SP_ID  = 2'd1,
      SP_INT = 2'd2,
      SP_MEM = 2'd3
   } space_e;

   localparam int NUM_EWIN = 3;
endpackage

// File: rtl/lwd_cfg.sv
module lwd_cfg #(
   parameter int          CFG_AW        = 8,
   parameter int          CFG_DEPTH     = 88,
   parameter logic [7:0]  CFG_MUL       = 8'd29,
   parameter logic [7:0]  CFG_SALT      = 8'hA6,
   parameter int          ENDIAN_BASE   = 'h2B,
   parameter int          ENDIAN_STRIDE = 4,
   parameter int          NUM_EWIN      = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_en,
   input  logic              cfg_wr,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [7:0]        cfg_wdata,
   output logic [7:0]        cfg_rdata,
   output logic [NUM_EWIN-1:0] endian_q
);
   localparam logic [CFG_AW:0] DEPTH_L = (CFG_AW+1)'(CFG_DEPTH);

   if (CFG_DEPTH > (1 << CFG_AW)) begin : g_chk_depth
      $error("lwd_cfg: CFG_DEPTH exceeds address space");
   end
   if (ENDIAN_BASE + (NUM_EWIN-1)*ENDIAN_STRIDE >= CFG_DEPTH) begin : g_chk_base
      $error("lwd_cfg: endian bytes outside table");
   end

   logic [NUM_EWIN-1:0] hit;
   wire unused_cfg_bits = ^cfg_wdata[7:1];

   for (genvar w = 0; w < NUM_EWIN; w++) begin : g_ebit
      localparam logic [CFG_AW-1:0] OFS = CFG_AW'(ENDIAN_BASE + w*ENDIAN_STRIDE);
      assign hit[w] = (cfg_addr == OFS);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        endian_q[w] <= 1'b0;
         else if (cfg_en && cfg_wr && hit[w]) endian_q[w] <= cfg_wdata[0];
      end
   end

   logic [7:0] mix;
   always_comb begin
      mix = 8'(cfg_addr * CFG_MUL);
      if ({1'b0, cfg_addr} < DEPTH_L)
         cfg_rdata = ((mix ^ CFG_SALT) & 8'hFE) | {7'd0, |(hit & endian_q)};
      else
         cfg_rdata = 8'h00;
   end

   // R7: a write to the first mode byte lands in mode bit 0
   a_r7_mode_write: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_en && cfg_wr && cfg_addr == CFG_AW'(ENDIAN_BASE))
      |=> (endian_q[0] == $past(cfg_wdata[0])));

   // R7: without a write enable the mode bits hold
   a_r7_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_en && cfg_wr) |=> $stable(endian_q));
endmodule

// File: rtl/lwd_lane.sv
module lwd_lane #(
   parameter int DW      = 16,
   parameter bit SWAP_EN = 1'b1
) (
   input  logic          swap,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] dout
);
   localparam int LANES = DW / 8;

   if (DW % 8 != 0 || LANES < 1) begin : g_chk_dw
      $error("lwd_lane: DW must be a multiple of 8");
   end

   if (SWAP_EN) begin : g_swap
      for (genvar b = 0; b < LANES; b++) begin : g_byte
         assign dout[b*8 +: 8] = swap ? din[(LANES-1-b)*8 +: 8] : din[b*8 +: 8];
      end
   end else begin : g_pass
      wire unused_swap = swap;
      assign dout = din;
   end
endmodule

// File: rtl/lwd_carve.sv
module lwd_carve
   import lwd_pkg::*;
#(
   parameter int ADDR_W       = 25,
   parameter int SLOT_W       = 2,
   parameter int OFF_W        = 23,
   parameter int CTL_OFF_W    = 8,
   parameter int REG_SLOT_LSB = 8,
   parameter int MEM16_OFF_W  = 23,
   parameter int MEM8_OFF_W   = 22
) (
   input  logic [1:0]          win,
   input  logic [ADDR_W-1:0]   addr,
   input  logic                size,
   input  logic [NUM_EWIN-1:0] endian_q,
   output logic [SLOT_W-1:0]   slot,
   output logic [1:0]          space,
   output logic [OFF_W-1:0]    offset,
   output logic                ctl,
   output logic                err,
   output logic                swap
);
   localparam int REG_SHORT_W = REG_SLOT_LSB - 2;
   localparam int REG_LONG_W  = REG_SLOT_LSB - 1;

   if (ADDR_W < MEM16_OFF_W + SLOT_W) begin : g_chk_a16
      $error("lwd_carve: ADDR_W too small for halfword window");
   end
   if (ADDR_W < MEM8_OFF_W + SLOT_W) begin : g_chk_a8
      $error("lwd_carve: ADDR_W too small for byte window");
   end
   if (OFF_W < MEM16_OFF_W || OFF_W < MEM8_OFF_W || OFF_W < CTL_OFF_W) begin : g_chk_off
      $error("lwd_carve: OFF_W too narrow");
   end
   if (REG_SLOT_LSB < 3 || ADDR_W < REG_SLOT_LSB + SLOT_W) begin : g_chk_reg
      $error("lwd_carve: bad register window layout");
   end

   logic [3:0]        be_ext;
   logic              be_win;
   logic [ADDR_W-1:0] ea;
   logic [1:0]        fld;

   assign be_ext = 4'({1'b0, endian_q});
   assign be_win = be_ext[win];
   assign ea     = addr ^ {{(ADDR_W-1){1'b0}}, (be_win & ~size)};
   assign swap   = be_win & size;
   assign err    = ((win == WIN_CTL) && !size) || ((win == WIN_MEM8) && size);
   assign ctl    = (win == WIN_CTL);
   assign fld    = ea[REG_SLOT_LSB-1 -: 2];

   always_comb begin
      slot   = '0;
      space  = SP_IO;
      offset = '0;
      unique case (win)
         WIN_CTL: begin
            offset[CTL_OFF_W-1:0] = ea[CTL_OFF_W-1:0];
         end
         WIN_REGIO: begin
            slot = ea[REG_SLOT_LSB +: SLOT_W];
            if (fld == 2'd2) begin
               space = SP_ID;
               offset[REG_SHORT_W-1:0] = ea[REG_SHORT_W-1:0];
            end else if (fld == 2'd3) begin
               space = SP_INT;
               offset[REG_SHORT_W-1:0] = ea[REG_SHORT_W-1:0];
            end else begin
               offset[REG_LONG_W-1:0] = ea[REG_LONG_W-1:0];
            end
         end
         WIN_MEM16: begin
            slot  = ea[MEM16_OFF_W +: SLOT_W];
            space = SP_MEM;
            offset[MEM16_OFF_W-1:0] = ea[MEM16_OFF_W-1:0];
         end
         default: begin
            slot  = ea[MEM8_OFF_W +: SLOT_W];
            space = SP_MEM;
            offset[MEM8_OFF_W-1:0] = ea[MEM8_OFF_W-1:0];
         end
      endcase
   end

   // R4: the byte window never asks for a lane swap
   always_comb begin
      a_r4_no_swap_mem8: assert (!(win == WIN_MEM8 && swap));
   end
endmodule

// File: rtl/lwin_decoder.sv
module lwin_decoder
   import lwd_pkg::*;
#(
   parameter int ADDR_W       = 25,
   parameter int NUM_SLOTS    = 4,
   parameter int DW           = 16,
   parameter int OFF_W        = 23,
   parameter int CTL_OFF_W    = 8,
   parameter int REG_SLOT_LSB = 8,
   parameter int MEM16_OFF_W  = 23,
   parameter int MEM8_OFF_W   = 22,
   parameter int CFG_AW       = 8,
   parameter int CFG_DEPTH    = 88,
   localparam int SLOT_W      = $clog2(NUM_SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic [1:0]        acc_win,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_size,
   input  logic              acc_wr,
   input  logic [DW-1:0]     acc_wdata,
   input  logic [NUM_SLOTS-1:0] slot_present,
   input  logic [DW-1:0]     mod_rdata,
   input  logic              cfg_en,
   input  logic              cfg_wr,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [7:0]        cfg_wdata,
   output logic [7:0]        cfg_rdata,
   output logic              dec_valid,
   output logic              dec_wr,
   output logic              dec_ctl,
   output logic              dec_err,
   output logic [SLOT_W-1:0] dec_slot,
   output logic [1:0]        dec_space,
   output logic [OFF_W-1:0]  dec_offset,
   output logic [DW-1:0]     dec_wdata,
   output logic [NUM_SLOTS-1:0] dec_sel,
   output logic [DW-1:0]     host_rdata
);
   if ((1 << SLOT_W) != NUM_SLOTS || NUM_SLOTS < 2) begin : g_chk_slots
      $error("lwin_decoder: NUM_SLOTS must be a power of two >= 2");
   end
   if (DW != 16) begin : g_chk_dw
      $error("lwin_decoder: halfword windows need DW == 16");
   end

   logic [NUM_EWIN-1:0] endian_q;
   logic [SLOT_W-1:0]   slot_d;
   logic [1:0]          space_d;
   logic [OFF_W-1:0]    off_d;
   logic                ctl_d, err_d, swap_d;
   logic [DW-1:0]       wlane, rlane;
   logic [NUM_SLOTS-1:0] sel_d;
   logic                q_swap;

   lwd_cfg #(
      .CFG_AW    (CFG_AW),
      .CFG_DEPTH (CFG_DEPTH),
      .NUM_EWIN  (NUM_EWIN)
   ) i_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_en    (cfg_en),
      .cfg_wr    (cfg_wr),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .endian_q  (endian_q)
   );

   lwd_carve #(
      .ADDR_W       (ADDR_W),
      .SLOT_W       (SLOT_W),
      .OFF_W        (OFF_W),
      .CTL_OFF_W    (CTL_OFF_W),
      .REG_SLOT_LSB (REG_SLOT_LSB),
      .MEM16_OFF_W  (MEM16_OFF_W),
      .MEM8_OFF_W   (MEM8_OFF_W)
   ) i_carve (
      .win      (acc_win),
      .addr     (acc_addr),
      .size     (acc_size),
      .endian_q (endian_q),
      .slot     (slot_d),
      .space    (space_d),
      .offset   (off_d),
      .ctl      (ctl_d),
      .err      (err_d),
      .swap     (swap_d)
   );

   lwd_lane #(.DW(DW), .SWAP_EN(1'b1)) i_wlane (
      .swap (swap_d),
      .din  (acc_wdata),
      .dout (wlane)
   );

   lwd_lane #(.DW(DW), .SWAP_EN(1'b1)) i_rlane (
      .swap (q_swap),
      .din  (mod_rdata),
      .dout (rlane)
   );

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_sel
      assign sel_d[s] = acc_valid && !err_d && !ctl_d &&
                        (slot_d == SLOT_W'(s)) && slot_present[s];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_valid  <= 1'b0;
         dec_wr     <= 1'b0;
         dec_ctl    <= 1'b0;
         dec_err    <= 1'b0;
         dec_slot   <= '0;
         dec_space  <= '0;
         dec_offset <= '0;
         dec_wdata  <= '0;
         dec_sel    <= '0;
         q_swap     <= 1'b0;
      end else begin
         dec_valid  <= acc_valid;
         dec_wr     <= acc_valid && acc_wr;
         dec_ctl    <= acc_valid && ctl_d && !err_d;
         dec_err    <= acc_valid && err_d;
         dec_slot   <= acc_valid ? slot_d  : '0;
         dec_space  <= acc_valid ? space_d : '0;
         dec_offset <= acc_valid ? off_d   : '0;
         dec_wdata  <= (acc_valid && acc_wr) ? wlane : '0;
         dec_sel    <= sel_d;
         q_swap     <= acc_valid && swap_d;
      end
   end

   assign host_rdata = (dec_valid && !dec_wr && (dec_ctl || (|dec_sel))) ? rlane : '0;

   // R9: an error never comes with a slot select
   a_r9_err_no_sel: assert property (@(posedge clk) disable iff (!rst_n)
      dec_err |-> (dec_sel == '0));

   // R9: a byte access to the control window is flagged
   a_r9_ctl_byte_err: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_win == WIN_CTL && !acc_size) |=> (dec_err && !dec_ctl));

   // R11: at most one slot selected
   a_r11_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dec_sel));

   // R11: a decode follows each access by exactly one cycle
   a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> dec_valid);
   a_r11_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> (!dec_valid && dec_sel == '0));

   // R10: reads with no target return zero
   a_r10_absent_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && !dec_wr && !dec_ctl && dec_sel == '0) |-> (host_rdata == '0));

   // R4: byte-window write data passes untouched
   a_r4_mem8_passthru: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_wr && acc_win == WIN_MEM8) |=> (dec_wdata == $past(acc_wdata)));
endmodule

// File: tb/test_lwin_decoder.sv
module test_lwin_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0;
   logic [1:0]  acc_win = '0;
   logic [24:0] acc_addr = '0;
   logic        acc_size = 1'b0;
   logic        acc_wr = 1'b0;
   logic [15:0] acc_wdata = '0;
   logic [3:0]  slot_present = 4'hF;
   logic [15:0] mod_rdata = '0;
   logic        cfg_en = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [7:0]  cfg_addr = '0;
   logic [7:0]  cfg_wdata = '0;
   logic [7:0]  cfg_rdata;
   logic        dec_valid, dec_wr, dec_ctl, dec_err;
   logic [1:0]  dec_slot, dec_space;
   logic [22:0] dec_offset;
   logic [15:0] dec_wdata, host_rdata;
   logic [3:0]  dec_sel;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   lwin_decoder i_lwin_decoder (
      .clk, .rst_n, .acc_valid, .acc_win, .acc_addr, .acc_size, .acc_wr,
      .acc_wdata, .slot_present, .mod_rdata, .cfg_en, .cfg_wr, .cfg_addr,
      .cfg_wdata, .cfg_rdata, .dec_valid, .dec_wr, .dec_ctl, .dec_err,
      .dec_slot, .dec_space, .dec_offset, .dec_wdata, .dec_sel, .host_rdata
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_cfg(input int a, input logic [2:0] be);
      logic [7:0] v;
      if (a >= 88) return 8'h00;
      v = (8'(a * 29) ^ 8'hA6) & 8'hFE;
      if (a == 'h2B) v[0] = be[0];
      if (a == 'h2F) v[0] = be[1];
      if (a == 'h33) v[0] = be[2];
      return v;
   endfunction

   task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      cfg_en = 1'b1; cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_en = 1'b0; cfg_wr = 1'b0;
   endtask

   task automatic cfg_read_chk(input int a, input logic [2:0] be, input string tag);
      cfg_addr = 8'(a);
      #1;
      chk(tag, {24'd0, cfg_rdata}, {24'd0, exp_cfg(a, be)});
   endtask

   task automatic set_be(input logic [2:0] be);
      cfg_write(8'h2B, {7'h7F, be[0]});
      cfg_write(8'h2F, {7'h55, be[1]});
      cfg_write(8'h33, {7'h2A, be[2]});
   endtask

   task automatic access(input logic [2:0] be, input logic [1:0] w, input logic [24:0] a,
                         input logic sz, input logic wr, input logic [15:0] wd,
                         input logic [15:0] rd, input logic [3:0] pres);
      logic        bew, err, ctl, swp;
      logic [24:0] ea;
      logic [1:0]  slot, sp;
      logic [22:0] off;
      logic [3:0]  sel;
      logic [15:0] ewd, erd;
      string       ftag;
      bew = (w == 2'd3) ? 1'b0 : be[w];
      ea  = a ^ {24'd0, bew & ~sz};
      err = (w == 2'd0 && !sz) || (w == 2'd3 && sz);
      ctl = (w == 2'd0) && !err;
      swp = bew & sz;
      off = '0; slot = '0; sp = 2'd0;
      case (w)
         2'd0: begin off[7:0] = ea[7:0]; ftag = "R5_R9_ctl"; end
         2'd1: begin
            slot = ea[9:8]; ftag = "R2_regio";
            if (ea[7:6] == 2'd2)      begin sp = 2'd1; off[5:0] = ea[5:0]; end
            else if (ea[7:6] == 2'd3) begin sp = 2'd2; off[5:0] = ea[5:0]; end
            else                      begin sp = 2'd0; off[6:0] = ea[6:0]; end
         end
         2'd2: begin slot = ea[24:23]; sp = 2'd3; off = ea[22:0]; ftag = "R3_mem16"; end
         default: begin slot = ea[23:22]; sp = 2'd3; off[21:0] = ea[21:0]; ftag = "R4_mem8"; end
      endcase
      sel = (!err && w != 2'd0 && pres[slot]) ? (4'b1 << slot) : 4'b0;
      ewd = wr ? (swp ? {wd[7:0], wd[15:8]} : wd) : 16'h0;
      erd = (!wr && (ctl || sel != 0)) ? (swp ? {rd[7:0], rd[15:8]} : rd) : 16'h0;

      @(negedge clk);
      acc_valid = 1'b1; acc_win = w; acc_addr = a; acc_size = sz; acc_wr = wr;
      acc_wdata = wd; mod_rdata = rd; slot_present = pres;
      @(negedge clk);
      acc_valid = 1'b0;
      chk({ftag, "_R5_slot"},   {30'd0, dec_slot},  {30'd0, slot});
      chk({ftag, "_space"},     {30'd0, dec_space}, {30'd0, sp});
      chk({ftag, "_R5_offset"}, {9'd0, dec_offset}, {9'd0, off});
      chk("R9_err",             {31'd0, dec_err},   {31'd0, err});
      chk("R11_ctl",            {31'd0, dec_ctl},   {31'd0, ctl});
      chk("R10_R11_sel",        {28'd0, dec_sel},   {28'd0, sel});
      chk("R11_valid",          {30'd0, dec_valid, dec_wr}, {30'd0, 1'b1, wr});
      chk("R4_R6_wdata",        {16'd0, dec_wdata}, {16'd0, ewd});
      chk("R6_R10_rdata",       {16'd0, host_rdata}, {16'd0, erd});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs idle during reset
      chk("R1_valid_in_reset", {31'd0, dec_valid}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1_outputs_after_reset",
          {12'd0, dec_valid, dec_err, dec_ctl, dec_sel, host_rdata},
          32'd0);
      cfg_read_chk('h2B, 3'b000, "R1_mode0_clear");
      cfg_read_chk('h2F, 3'b000, "R1_mode1_clear");
      cfg_read_chk('h33, 3'b000, "R1_mode2_clear");

      // R8: whole configuration space with all modes clear
      for (int a = 0; a < 256; a++) cfg_read_chk(a, 3'b000, "R8_cfg_table");

      // R7: every mode pattern, plus writes elsewhere that must be ignored
      for (int p = 0; p < 8; p++) begin
         set_be(3'(p));
         cfg_write(8'h2A, 8'hFF);
         cfg_write(8'h2C, 8'hFF);
         cfg_write(8'h30, 8'hFF);
         cfg_write(8'h5A, 8'hFF);
         cfg_read_chk('h2B, 3'(p), "R7_mode0");
         cfg_read_chk('h2F, 3'(p), "R7_mode1");
         cfg_read_chk('h33, 3'(p), "R7_mode2");
         cfg_read_chk('h2A, 3'(p), "R7_other_ignored");
         cfg_read_chk('h2C, 3'(p), "R7_other_ignored");
         cfg_read_chk('h5A, 3'(p), "R8_beyond_table");
      end

      // R2..R6, R9..R11: sweep modes x windows x sizes x addresses
      for (int p = 0; p < 8; p++) begin
         set_be(3'(p));
         for (int w = 0; w < 4; w++) begin
            for (int sz = 0; sz < 2; sz++) begin
               for (int k = 0; k < 40; k++) begin
                  logic [31:0] h;
                  logic [24:0] a;
                  logic [3:0]  pres;
                  h = 32'(k) * 32'h9E3779B1;
                  a = 25'(h >> 5) ^ 25'(w * 'h123);
                  if (k == 0) a = '0;
                  if (k == 1) a = '1;
                  if (w == 1 && k >= 2 && k < 18) a[9:6] = 4'(k - 2);
                  pres = (k % 3 == 0) ? (4'hF ^ (4'h1 << ((k / 3) % 4))) : 4'hF;
                  access(3'(p), 2'(w), a, sz[0], k[0],
                         16'(k * 'h1357) ^ 16'hA5C3, 16'(k * 'h2469 + 7), pres);
                  if (k % 7 == 0) begin
                     @(negedge clk);
                     // R11: decode lasts one cycle only
                     chk("R11_idle_after", {27'd0, dec_valid, dec_sel},
                         32'd0);
                  end
               end
            end
         end
      end

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule